// File: doc/BRIEF.md
# Packet Radio Modem Register Bank

This block is the host-facing register side of a packet radio modem. A host talks to it over a four-wire serial bus in clock mode 0. Each access is one frame of exactly two bytes, framed by chip select held low. The first byte carries a write flag and a 7-bit register address. The second byte is either the data to store or a dummy byte, during which the addressed register is shifted back to the host.

Behind the serial front end are four things. A 256-byte packet buffer is reached through a data-port address, with a host-set pointer. There is an operating-mode register and a write-one-to-clear event register. A stand-in transmit engine consumes the programmed payload length at a fixed pace, raises a done event and drops the modem back to standby by itself.

The serial sequencer is a state machine with these states:
- FR_IDLE: waits for chip select.
- FR_ADDR: collects the first byte.
- FR_LOAD: a one-cycle read fetch, used only on reads.
- FR_DATA: collects or returns the second byte.
- FR_COMMIT: a one-cycle write strobe, used only on writes.
- FR_HOLD: waits for chip select to rise.

Its transitions are:
- FR_IDLE→FR_ADDR when chip select falls.
- FR_ADDR→FR_LOAD (read) or FR_ADDR→FR_DATA (write) after the eighth bit.
- FR_LOAD→FR_DATA.
- FR_DATA→FR_COMMIT (write) or FR_DATA→FR_HOLD (read) after the sixteenth bit.
- FR_COMMIT→FR_HOLD.
- Any state→FR_IDLE when chip select rises. FR_COMMIT always issues its strobe first.

The transmit engine has two states: TX_IDLE and TX_SEND. It goes TX_IDLE→TX_SEND when the mode code becomes transmit. It goes TX_SEND→TX_IDLE on completion, or when the host moves the mode away from transmit.

Top module: `radio_regbank`

## Requirements
- R1: A frame is chip select low for 16 SCK rising edges. Input bits are sampled on SCK rising edges, MSB first. Bit 7 of the first byte set means write and clear means read. Bits 6:0 of the first byte are the address. The second byte is the write data.
- R2: A write to address 0x00 stores the byte in the buffer at the pointer (address 0x0D), then advances the pointer by one modulo 256.
- R3: A read of address 0x00 returns the buffer byte at the pointer, then advances the pointer by one modulo 256.
- R4: Four registers read back the last value written: the pointer (0x0D), the transmit base (0x0E), the receive base (0x0F) and the payload length (0x22).
- R5: Address 0x42 always reads 0x12. Addresses 0x10 (current receive address) and 0x13 (received byte count) read 0x00. Writes to these three addresses change nothing.
- R6: Every other unimplemented address reads 0x00, and writes to it change nothing.
- R7: The event register at 0x12 has these bits: bit 7 receive timeout, bit 6 receive done, bit 5 payload CRC error, bit 3 transmit done. Each bit written with 1 clears. Bits written with 0 keep their value.
- R8: The mode register at 0x01 keeps bit 7 (long-range) and a 3-bit code in bits 2:0. The codes are 0 sleep, 1 standby, 3 transmit, 5 continuous receive and 6 single receive. Bits 6:3 read 0. After reset it reads 0x01.
- R9: After code 3 is written, the engine runs for payload length × BYTE_CYCLES clocks. It then sets event bit 3 and returns the code to 1, keeping bit 7.
- R10: With a payload length of 0, the transmit-done event and the return to standby follow within two clocks of the write.
- R11: If the code leaves 3 before the engine finishes, no transmit-done event is raised and the written code stays.
- R12: A frame whose chip select rises before the sixteenth SCK rising edge writes nothing.
- R13: MISO changes only after an SCK falling edge, or when chip select is high. The read byte is returned MSB first, so each data bit is stable across the rising edge that samples it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_sck | input | 1 | Serial clock from host, idle low |
| spi_csn | input | 1 | Active-low chip select |
| spi_mosi | input | 1 | Serial data from host |
| spi_miso | output | 1 | Serial data to host |

## Verification
The assertions assume that each SCK half period lasts at least three system clocks. This lets every SCK edge cross the two-stage synchroniser and be acted on before the opposite edge arrives. They also assume that MOSI is steady around each rising edge. The stimulus holds each SCK level for four clocks. It changes MOSI only while SCK is low, and it leaves eight clocks of chip-select-high gap between frames, so every frame begins from FR_IDLE. The sweeps cover all 128 addresses and all 256 buffer locations. Expected register values, buffer contents and pointer wrap are computed arithmetically from the address and index.

// File: rtl/radio_pkg.sv
package radio_pkg;

    localparam int ADDR_W = 7;
    localparam int DATA_W = 8;

    // register addresses the host decodes
    localparam logic [ADDR_W-1:0] A_PORT   = 7'h00;
    localparam logic [ADDR_W-1:0] A_MODE   = 7'h01;
    localparam logic [ADDR_W-1:0] A_PTR    = 7'h0D;
    localparam logic [ADDR_W-1:0] A_TXBASE = 7'h0E;
    localparam logic [ADDR_W-1:0] A_RXBASE = 7'h0F;
    localparam logic [ADDR_W-1:0] A_RXCUR  = 7'h10;
    localparam logic [ADDR_W-1:0] A_EVENT  = 7'h12;
    localparam logic [ADDR_W-1:0] A_RXCNT  = 7'h13;
    localparam logic [ADDR_W-1:0] A_PLEN   = 7'h22;
    localparam logic [ADDR_W-1:0] A_ID     = 7'h42;

    // mode codes
    localparam logic [2:0] MC_SLEEP = 3'd0;
    localparam logic [2:0] MC_STBY  = 3'd1;
    localparam logic [2:0] MC_TX    = 3'd3;

    // event register layout
    localparam int                EV_TXDONE = 3;
    localparam logic [DATA_W-1:0] EV_MASK   = 8'hE8;

    typedef enum logic [2:0] {
        FR_IDLE,
        FR_ADDR,
        FR_LOAD,
        FR_DATA,
        FR_COMMIT,
        FR_HOLD
    } frame_state_t;

    typedef enum logic [0:0] {
        TX_IDLE,
        TX_SEND
    } tx_state_t;

endpackage

// File: rtl/spi_sync.sv
module spi_sync #(
    parameter int          STAGES  = 2,
    parameter int          W       = 3,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [STAGES-1:0][W-1:0] chain_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= {STAGES{RST_VAL}};
        else        chain_q <= {chain_q[STAGES-2:0], d};
    end

    assign q = chain_q[STAGES-1];
endmodule

// File: rtl/spi_frame.sv
module spi_frame
    import radio_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sck_s,
    input  logic              csn_s,
    input  logic              mosi_s,
    input  logic [DATA_W-1:0] rdata,
    output logic              rd_stb,
    output logic              wr_stb,
    output logic [ADDR_W-1:0] addr,
    output logic [DATA_W-1:0] wdata,
    output logic              miso
);
    frame_state_t      state_q, state_d;
    logic              sck_d;
    logic              rise, fall;
    logic [2:0]        bit_q;
    logic [DATA_W-1:0] rx_sh_q, tx_sh_q;
    logic              is_wr_q;
    logic              miso_q;

    assign rise = sck_s & ~sck_d;
    assign fall = ~sck_s & sck_d;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= FR_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            FR_IDLE:   if (!csn_s) state_d = FR_ADDR;
            FR_ADDR:   if (csn_s) state_d = FR_IDLE;
                       else if (rise && bit_q == 3'd7) state_d = is_wr_q ? FR_DATA : FR_LOAD;
            FR_LOAD:   state_d = csn_s ? FR_IDLE : FR_DATA;
            FR_DATA:   if (csn_s) state_d = FR_IDLE;
                       else if (rise && bit_q == 3'd7) state_d = is_wr_q ? FR_COMMIT : FR_HOLD;
            FR_COMMIT: state_d = csn_s ? FR_IDLE : FR_HOLD;
            FR_HOLD:   if (csn_s) state_d = FR_IDLE;
            default:   state_d = FR_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        rd_stb = (state_q == FR_LOAD);
        wr_stb = (state_q == FR_COMMIT);
    end

    // shift datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sck_d   <= 1'b0;
            bit_q   <= '0;
            rx_sh_q <= '0;
            tx_sh_q <= '0;
            is_wr_q <= 1'b0;
            addr    <= '0;
            wdata   <= '0;
            miso_q  <= 1'b0;
        end else begin
            sck_d <= sck_s;
            if (state_q == FR_IDLE) begin
                bit_q   <= '0;
                tx_sh_q <= '0;
            end else if (rise && (state_q == FR_ADDR || state_q == FR_DATA)) begin
                bit_q   <= bit_q + 3'd1;
                rx_sh_q <= {rx_sh_q[DATA_W-2:0], mosi_s};
                if (state_q == FR_ADDR && bit_q == 3'd0) is_wr_q <= mosi_s;
                if (state_q == FR_ADDR && bit_q == 3'd7) addr <= {rx_sh_q[ADDR_W-2:0], mosi_s};
                if (state_q == FR_DATA && bit_q == 3'd7) wdata <= {rx_sh_q[DATA_W-2:0], mosi_s};
            end
            if (state_q == FR_LOAD) tx_sh_q <= rdata;
            if (csn_s) begin
                miso_q <= 1'b0;
            end else if (fall && state_q == FR_DATA) begin
                miso_q  <= tx_sh_q[DATA_W-1];
                tx_sh_q <= {tx_sh_q[DATA_W-2:0], 1'b0};
            end
        end
    end

    assign miso = miso_q;

    AST_MISO_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n) !$stable(miso_q) |-> $past(fall || csn_s)); // R13
    AST_STROBE_NEEDS_SELECT: assert property (@(posedge clk) disable iff (!rst_n) $rose(wr_stb) |-> $past(!csn_s)); // R12
endmodule

// File: rtl/reg_core.sv
module reg_core
    import radio_pkg::*;
#(
    parameter int                BYTE_CYCLES = 16,
    parameter logic [DATA_W-1:0] CHIP_ID     = 8'h12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_stb,
    input  logic              wr_stb,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata
);
    localparam int BUF_DEPTH = 1 << DATA_W;
    localparam int TMR_W     = $clog2(BYTE_CYCLES + 1);
    localparam logic [TMR_W-1:0] TMR_LAST = TMR_W'(BYTE_CYCLES - 1);

    logic [DATA_W-1:0] pkt_mem [BUF_DEPTH];
    logic [DATA_W-1:0] ptr_q, txbase_q, rxbase_q, plen_q, event_q, sent_q;
    logic              lr_q;
    logic [2:0]        code_q;
    logic [TMR_W-1:0]  tmr_q;
    tx_state_t         tx_q, tx_d;
    logic              tx_done;
    logic              wr_hit_port;

    assign wr_hit_port = wr_stb && addr == A_PORT;

    // transmit state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) tx_q <= TX_IDLE;
        else        tx_q <= tx_d;
    end

    always_comb begin
        tx_d = tx_q;
        unique case (tx_q)
            TX_IDLE: if (code_q == MC_TX) tx_d = TX_SEND;
            TX_SEND: if (code_q != MC_TX || tx_done) tx_d = TX_IDLE;
            default: tx_d = TX_IDLE;
        endcase
    end

    // transmit outputs
    always_comb begin
        tx_done = (tx_q == TX_SEND) && (code_q == MC_TX) && (sent_q == plen_q);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tmr_q  <= '0;
            sent_q <= '0;
        end else if (tx_q != TX_SEND) begin
            tmr_q  <= '0;
            sent_q <= '0;
        end else if (tmr_q == TMR_LAST) begin
            tmr_q  <= '0;
            sent_q <= sent_q + 1'b1;
        end else begin
            tmr_q <= tmr_q + 1'b1;
        end
    end

    // host-visible registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ptr_q    <= '0;
            txbase_q <= '0;
            rxbase_q <= '0;
            plen_q   <= '0;
            event_q  <= '0;
            lr_q     <= 1'b0;
            code_q   <= MC_STBY;
        end else begin
            if ((wr_stb || rd_stb) && addr == A_PORT) ptr_q <= ptr_q + 1'b1;
            if (wr_stb) begin
                unique case (addr)
                    A_PTR:    ptr_q    <= wdata;
                    A_TXBASE: txbase_q <= wdata;
                    A_RXBASE: rxbase_q <= wdata;
                    A_PLEN:   plen_q   <= wdata;
                    A_MODE:   begin
                                  lr_q   <= wdata[7];
                                  code_q <= wdata[2:0];
                              end
                    default:  ;
                endcase
            end
            event_q <= ((event_q & ~((wr_stb && addr == A_EVENT) ? wdata : '0))
                        | (tx_done ? (DATA_W'(1) << EV_TXDONE) : '0)) & EV_MASK;
            if (tx_done) code_q <= MC_STBY;
        end
    end

    always_ff @(posedge clk) begin
        if (wr_hit_port) pkt_mem[ptr_q] <= wdata;
    end

    always_comb begin
        case (addr)
            A_PORT:   rdata = pkt_mem[ptr_q];
            A_MODE:   rdata = {lr_q, 4'b0000, code_q};
            A_PTR:    rdata = ptr_q;
            A_TXBASE: rdata = txbase_q;
            A_RXBASE: rdata = rxbase_q;
            A_EVENT:  rdata = event_q;
            A_PLEN:   rdata = plen_q;
            A_ID:     rdata = CHIP_ID;
            default:  rdata = '0;
        endcase
    end

    AST_DONE_TO_STANDBY: assert property (@(posedge clk) disable iff (!rst_n) tx_done |=> (code_q == MC_STBY && event_q[EV_TXDONE])); // R9
    AST_ABANDON_IDLE: assert property (@(posedge clk) disable iff (!rst_n) (tx_q == TX_SEND && code_q != MC_TX) |=> (tx_q == TX_IDLE)); // R11
    AST_EVENT_W1C: assert property (@(posedge clk) disable iff (!rst_n) (wr_stb && addr == A_EVENT && !tx_done) |=> ((event_q & $past(wdata)) == '0)); // R7
    AST_PTR_STEP: assert property (@(posedge clk) disable iff (!rst_n) ((wr_stb || rd_stb) && addr == A_PORT) |=> (ptr_q == DATA_W'($past(ptr_q) + 1'b1))); // R2
endmodule

// File: rtl/radio_regbank.sv
module radio_regbank
    import radio_pkg::*;
#(
    parameter int BYTE_CYCLES = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic spi_sck,
    input  logic spi_csn,
    input  logic spi_mosi,
    output logic spi_miso
);
    logic              sck_s, csn_s, mosi_s;
    logic              rd_stb, wr_stb;
    logic [ADDR_W-1:0] addr;
    logic [DATA_W-1:0] wdata, rdata;

    spi_sync #(.STAGES(SYNC_STAGES), .W(3), .RST_VAL(3'b010)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({spi_sck, spi_csn, spi_mosi}),
        .q     ({sck_s, csn_s, mosi_s})
    );

    spi_frame u_frame (
        .clk    (clk),
        .rst_n  (rst_n),
        .sck_s  (sck_s),
        .csn_s  (csn_s),
        .mosi_s (mosi_s),
        .rdata  (rdata),
        .rd_stb (rd_stb),
        .wr_stb (wr_stb),
        .addr   (addr),
        .wdata  (wdata),
        .miso   (spi_miso)
    );

    reg_core #(.BYTE_CYCLES(BYTE_CYCLES), .CHIP_ID(8'h12)) u_core (
        .clk    (clk),
        .rst_n  (rst_n),
        .rd_stb (rd_stb),
        .wr_stb (wr_stb),
        .addr   (addr),
        .wdata  (wdata),
        .rdata  (rdata)
    );
endmodule

// File: tb/radio_regbank_test.sv
module radio_regbank_test;
    localparam int CLK_PERIOD = 10;
    localparam int HALF       = 4;
    localparam int BYTE_CYC   = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sck = 1'b0, csn = 1'b1, mosi = 1'b0;
    logic miso;
    int   vectors = 0;
    int   fails = 0;

    radio_regbank #(.BYTE_CYCLES(BYTE_CYC), .SYNC_STAGES(2)) uut (
        .clk(clk), .rst_n(rst_n), .spi_sck(sck), .spi_csn(csn),
        .spi_mosi(mosi), .spi_miso(miso)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        vectors++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual %02h expected %02h", req, act, exp);
        end
    endtask

    task automatic frame(input logic [7:0] b0, input logic [7:0] b1, input int nbits,
                         output logic [7:0] rd, output logic steady);
        logic seen;
        rd = '0;
        steady = 1'b1;
        seen = 1'b0;
        @(negedge clk) csn = 1'b0;
        repeat (HALF) @(negedge clk);
        for (int i = 0; i < nbits; i++) begin
            mosi = (i < 8) ? b0[7-i] : b1[15-i];
            repeat (HALF) @(negedge clk);
            if (i >= 8) begin
                rd[15-i] = miso;
                seen = miso;
            end
            sck = 1'b1;
            repeat (HALF) @(negedge clk);
            if (i >= 8 && miso !== seen) steady = 1'b0;
            sck = 1'b0;
        end
        repeat (HALF) @(negedge clk);
        csn = 1'b1;
        mosi = 1'b0;
        repeat (2*HALF) @(negedge clk);
    endtask

    task automatic wr(input logic [6:0] a, input logic [7:0] d);
        logic [7:0] r;
        logic s;
        frame({1'b1, a}, d, 16, r, s);
    endtask

    task automatic rd(input logic [6:0] a, output logic [7:0] d);
        logic s;
        frame({1'b0, a}, 8'h00, 16, d, s);
        chk("R13 miso steady over sampling edge", {7'd0, s}, 8'h01);
    endtask

    function automatic logic [7:0] pat(input int a);
        return 8'((a * 37 + 5) & 8'hFF);
    endfunction

    initial begin
        repeat (190000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        logic [7:0] r;
        logic       s;
        logic [7:0] exp;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);

        // R8 reset value
        rd(7'h01, r); chk("R8 mode after reset", r, 8'h01);

        // R4 R5 R6 sweep of every address except port, mode and events
        for (int a = 1; a < 128; a++)
            if (a != 8'h01 && a != 8'h12) wr(7'(a), pat(a));
        for (int a = 1; a < 128; a++) begin
            rd(7'(a), r);
            if (a == 8'h0D || a == 8'h0E || a == 8'h0F || a == 8'h22) begin
                chk("R4 read back", r, pat(a));
            end else if (a == 8'h42) begin
                chk("R5 id constant", r, 8'h12);
            end else if (a == 8'h10 || a == 8'h13) begin
                chk("R5 read-only zero", r, 8'h00);
            end else if (a == 8'h01) begin
                chk("R8 mode untouched", r, 8'h01);
            end else if (a == 8'h12) begin
                chk("R7 events idle", r, 8'h00);
            end else begin
                chk("R6 unimplemented zero", r, 8'h00);
            end
        end

        // R2 R3 full buffer sweep through the port
        wr(7'h0D, 8'h00);
        for (int i = 0; i < 256; i++) wr(7'h00, 8'((i * 7 + 3) & 8'hFF));
        rd(7'h0D, r); chk("R2 pointer wrapped after 256 writes", r, 8'h00);
        for (int i = 0; i < 256; i++) begin
            rd(7'h00, r);
            chk("R3 port read", r, 8'((i * 7 + 3) & 8'hFF));
        end
        rd(7'h0D, r); chk("R3 pointer wrapped after 256 reads", r, 8'h00);

        // R2 R3 wrap near the top
        wr(7'h0D, 8'hFE);
        wr(7'h00, 8'hAA); wr(7'h00, 8'hBB); wr(7'h00, 8'hCC);
        rd(7'h0D, r); chk("R2 pointer wrap", r, 8'h01);
        wr(7'h0D, 8'hFE);
        rd(7'h00, r); chk("R3 byte at FE", r, 8'hAA);
        rd(7'h00, r); chk("R3 byte at FF", r, 8'hBB);
        rd(7'h00, r); chk("R3 byte at 00", r, 8'hCC);

        // R12 aborted frame; R1 write flag and address decode
        wr(7'h0E, 8'h33);
        frame({1'b1, 7'h0E}, 8'h77, 12, r, s);
        rd(7'h0E, r); chk("R12 aborted write discarded", r, 8'h33);
        frame({1'b0, 7'h0E}, 8'h55, 16, r, s);
        chk("R1 read frame returns data, stores nothing", r, 8'h33);
        rd(7'h0E, r); chk("R1 read did not write", r, 8'h33);

        // R8 mode field
        wr(7'h01, 8'h85); rd(7'h01, r); chk("R8 continuous receive", r, 8'h85);
        wr(7'h01, 8'h7E); rd(7'h01, r); chk("R8 middle bits read zero", r, 8'h06);
        wr(7'h01, 8'h00); rd(7'h01, r); chk("R8 sleep", r, 8'h00);

        // R10 zero-length transmit
        wr(7'h22, 8'h00);
        wr(7'h01, 8'h83);
        rd(7'h01, r); chk("R10 back to standby", r, 8'h81);
        rd(7'h12, r); chk("R10 transmit done", r, 8'h08);

        // R7 write-one-to-clear
        wr(7'h12, 8'h00); rd(7'h12, r); chk("R7 zero write keeps", r, 8'h08);
        wr(7'h12, 8'hF7); rd(7'h12, r); chk("R7 other ones keep bit3", r, 8'h08);
        wr(7'h12, 8'hFF); rd(7'h12, r); chk("R7 one clears", r, 8'h00);

        // R9 timed transmit: 20 bytes at BYTE_CYC clocks each
        wr(7'h22, 8'd20);
        wr(7'h01, 8'h03);
        rd(7'h01, r); chk("R9 still transmitting", r, 8'h03);
        repeat (20 * BYTE_CYC + 80) @(negedge clk);
        rd(7'h01, r); chk("R9 standby after send", r, 8'h01);
        rd(7'h12, r); chk("R9 done flag", r, 8'h08);
        wr(7'h12, 8'h08);

        // R11 transmit abandoned
        wr(7'h22, 8'd50);
        wr(7'h01, 8'h83);
        wr(7'h01, 8'h85);
        repeat (50 * BYTE_CYC + 200) @(negedge clk);
        rd(7'h12, r); chk("R11 no done flag", r, 8'h00);
        exp = 8'h85;
        rd(7'h01, r); chk("R11 mode kept", r, exp);

        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end
endmodule